// File: doc/BRIEF.md
# Bus arbiter command channel

This block is one command channel of a controller for a two-wire power-management serial bus. Software loads up to two 32-bit write-data words, then writes a command word. The command word holds an opcode, a 4-bit target ID, a 16-bit register address and a byte count. The channel checks the opcode and the target permission. It then presents one request on a bus-side handshake port and waits for an acknowledge or a negative acknowledge. For read opcodes it keeps the returned bytes in two read-data words. Every transaction leaves a sticky status code that software polls.

The bus-side port is a plain level request with one-cycle responses. A behavioural responder drives it in the bench. A transaction that receives no response within a parameterised number of cycles is abandoned and reported as dropped. This keeps the worst-case wait well inside the polling budget software allows, which is about a hundred microseconds.

Top module: `sbus_cmd_chan`

## Requirements
- R1: After reset the status word reads 0, the config word reads 0x0000FFFF (all target IDs allowed), both read-data words read 0, the command word reads 0 and `bus_req` is low.
- R2: A command write accepted while idle raises `bus_req` at the next clock edge. `bus_opc` = cmd[31:27], `bus_sid` = cmd[23:20], `bus_addr` = cmd[19:4] and `bus_bc` = cmd[2:0] (byte count minus one). All these fields stay constant while `bus_req` is high.
- R3: For write opcodes (0, 2, 9, 14, 16), `bus_wdata` byte i (bits 8i+7:8i) equals byte i of {wdata1, wdata0}, least-significant byte first, for i up to the byte count, and is 0 above it. The value is captured when the command is written, and later writes to the data words do not change it. For all other opcodes `bus_wdata` is 0.
- R4: On an acknowledge to a read opcode (1, 8, 13, 15), the read-data words take bytes 0..bc of `bus_rdata` with zero above. They change at the same edge that sets done.
- R5: Status bit 0 is done, bit 1 failure, bit 2 denied and bit 3 dropped. A clean acknowledge yields 0x1, and `bus_req` falls at that edge.
- R6: A negative acknowledge yields status 0x3 and leaves the read-data words unchanged.
- R7: A command whose target ID has its bit clear in config[15:0] yields status 0x5 and never raises `bus_req`.
- R8: Opcodes 10, 11, 12 and 17 to 31 are invalid. They yield status 0x3 and never raise `bus_req`.
- R9: If no response arrives while `bus_req` has been high for TIMEOUT_CYC cycles, `bus_req` falls and the status becomes 0x9.
- R10: A command write while a transaction is in flight is ignored: the bus fields and the command word are unchanged. Done and dropped are ORed into the status, and the in-flight result is ORed in later.
- R11: An accepted command write clears the status to 0 before the new transaction completes.
- R12: Control opcodes 3 to 7 drive `bus_bc` = 0 and `bus_wdata` = 0 whatever the command carries, and leave the read-data words unchanged on acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte offset in channel window: 0x00 cmd, 0x04 config, 0x08 status, 0x10/0x14 write data, 0x18/0x1C read data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| bus_req | output | 1 | Request to bus side, high while a transaction is in flight |
| bus_opc | output | 5 | Opcode of the request |
| bus_sid | output | 4 | Target ID |
| bus_addr | output | 16 | Target register address |
| bus_bc | output | 3 | Byte count minus one |
| bus_wdata | output | 64 | Masked write bytes, byte 0 in bits 7:0 |
| bus_ack | input | 1 | One-cycle acknowledge from bus side |
| bus_nack | input | 1 | One-cycle negative acknowledge from bus side |
| bus_rdata | input | 64 | Read bytes returned with acknowledge |

## Verification
A software command write can land in the same clock cycle as the bus-side response that ends the in-flight transaction. Because the channel is still busy at that edge, the write must be treated as ignored rather than starting a new transaction. The bench provokes this by asserting `bus_ack` and a command write on one edge during a read. It then judges the outcome: status must read done plus dropped, the read data must hold the returned byte, the bus fields must still show the first command, and `bus_req` must stay low afterwards. The collision between a command write and the timeout is covered by the same OR-merge of status codes.

// File: rtl/sbus_cmd_chan.sv
module sbus_cmd_chan #(
  parameter int TIMEOUT_CYC = 2000,
  parameter logic [31:0] CFG_RST = 32'h0000_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        bus_req,
  output logic [4:0]  bus_opc,
  output logic [3:0]  bus_sid,
  output logic [15:0] bus_addr,
  output logic [2:0]  bus_bc,
  output logic [63:0] bus_wdata,
  input  logic        bus_ack,
  input  logic        bus_nack,
  input  logic [63:0] bus_rdata
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [4:0] A_CMD = 5'h00, A_CFG = 5'h04, A_STAT = 5'h08,
                         A_WD0 = 5'h10, A_WD1 = 5'h14, A_RD0 = 5'h18, A_RD1 = 5'h1C;
  localparam logic [3:0] ST_OK = 4'b0001, ST_FAIL = 4'b0011,
                         ST_DENY = 4'b0101, ST_DROP = 4'b1001;

  function automatic logic [63:0] byte_mask(input logic [2:0] bc);
    for (int i = 0; i < 8; i++) byte_mask[i*8 +: 8] = (i <= int'(bc)) ? 8'hFF : 8'h00;
  endfunction
  function automatic logic op_valid(input logic [4:0] op);
    return (op <= 5'd9) || (op >= 5'd13 && op <= 5'd16);
  endfunction
  function automatic logic op_ctl(input logic [4:0] op);
    return op >= 5'd3 && op <= 5'd7;
  endfunction
  function automatic logic op_rd(input logic [4:0] op);
    return op == 5'd1 || op == 5'd8 || op == 5'd13 || op == 5'd15;
  endfunction
  function automatic logic op_wr(input logic [4:0] op);
    return op == 5'd0 || op == 5'd2 || op == 5'd9 || op == 5'd14 || op == 5'd16;
  endfunction

  logic [31:0]      cmd_q, cfg_q, wd0_q, wd1_q, rd0_q, rd1_q;
  logic [3:0]       stat_q;
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  wire [4:0] n_opc = reg_wdata[31:27];
  wire [3:0] n_sid = reg_wdata[23:20];
  wire [2:0] n_bc  = reg_wdata[2:0];
  wire cmd_wr   = reg_wr && (reg_addr == A_CMD);
  wire resp     = bus_ack || bus_nack;
  wire time_up  = busy_q && !resp && (cnt_q == CNT_W'(TIMEOUT_CYC - 1));
  wire [63:0] rmask = byte_mask(bus_bc);

  wire [3:0] stat_add = (cmd_wr   ? ST_DROP : 4'b0)
                      | (bus_nack ? ST_FAIL : (bus_ack ? ST_OK : 4'b0))
                      | (time_up  ? ST_DROP : 4'b0);

  assign bus_req = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0; cfg_q <= CFG_RST; wd0_q <= '0; wd1_q <= '0;
      rd0_q <= '0; rd1_q <= '0; stat_q <= '0; busy_q <= 1'b0; cnt_q <= '0;
      bus_opc <= '0; bus_sid <= '0; bus_addr <= '0; bus_bc <= '0; bus_wdata <= '0;
    end else begin
      if (reg_wr && reg_addr == A_CFG) cfg_q <= reg_wdata;
      if (reg_wr && reg_addr == A_WD0) wd0_q <= reg_wdata;
      if (reg_wr && reg_addr == A_WD1) wd1_q <= reg_wdata;
      if (busy_q) begin
        stat_q <= stat_q | stat_add;
        cnt_q  <= cnt_q + 1'b1;
        if (resp || time_up) busy_q <= 1'b0;
        if (bus_ack && !bus_nack && op_rd(bus_opc)) begin
          rd0_q <= bus_rdata[31:0]  & rmask[31:0];
          rd1_q <= bus_rdata[63:32] & rmask[63:32];
        end
      end else if (cmd_wr) begin
        cmd_q <= reg_wdata;
        cnt_q <= '0;
        if (!op_valid(n_opc)) begin
          stat_q <= ST_FAIL;
        end else if (!cfg_q[n_sid]) begin
          stat_q <= ST_DENY;
        end else begin
          stat_q    <= '0;
          busy_q    <= 1'b1;
          bus_opc   <= n_opc;
          bus_sid   <= n_sid;
          bus_addr  <= reg_wdata[19:4];
          bus_bc    <= op_ctl(n_opc) ? 3'd0 : n_bc;
          bus_wdata <= op_wr(n_opc) ? ({wd1_q, wd0_q} & byte_mask(n_bc)) : 64'd0;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CMD:   reg_rdata = cmd_q;
      A_CFG:   reg_rdata = cfg_q;
      A_STAT:  reg_rdata = {28'd0, stat_q};
      A_WD0:   reg_rdata = wd0_q;
      A_WD1:   reg_rdata = wd1_q;
      A_RD0:   reg_rdata = rd0_q;
      A_RD1:   reg_rdata = rd1_q;
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

module sbus_cmd_chan_chk #(parameter int TIMEOUT_CYC = 2000) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_req,
  input logic        bus_ack,
  input logic        bus_nack,
  input logic [4:0]  bus_opc,
  input logic [15:0] bus_addr,
  input logic [2:0]  bus_bc,
  input logic [63:0] bus_wdata,
  input logic [3:0]  stat
);
  int req_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) req_run <= 0;
    else req_run <= bus_req ? req_run + 1 : 0;

  p_fields_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_opc) && $stable(bus_wdata)));
  p_ack_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !bus_nack) |=> (stat[0] && !bus_req));
  p_nack_fail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_nack) |=> (stat[1:0] == 2'b11));
  p_denied_noreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stat[2] |-> !bus_req);
  p_wait_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_run <= TIMEOUT_CYC);
  p_ctl_nodata_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_opc >= 5'd3 && bus_opc <= 5'd7) |-> (bus_bc == 3'd0 && bus_wdata == 64'd0));
endmodule

bind sbus_cmd_chan sbus_cmd_chan_chk #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack), .bus_nack(bus_nack),
  .bus_opc(bus_opc), .bus_addr(bus_addr), .bus_bc(bus_bc), .bus_wdata(bus_wdata),
  .stat(stat_q));

// File: tb/test_sbus_cmd_chan.sv
`timescale 1ns/1ps
module test_sbus_cmd_chan;
  localparam int TMO = 2000;
  localparam logic [4:0] A_CMD = 5'h00, A_CFG = 5'h04, A_STAT = 5'h08,
                         A_WD0 = 5'h10, A_WD1 = 5'h14, A_RD0 = 5'h18, A_RD1 = 5'h1C;
  localparam logic [31:0] WD0 = 32'hA3A2A1A0, WD1 = 32'hB7B6B5B4;
  localparam logic [63:0] RDAT = 64'h8877665544332211;

  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, bus_ack = 1'b0, bus_nack = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic bus_req;
  logic [4:0] bus_opc;
  logic [3:0] bus_sid;
  logic [15:0] bus_addr;
  logic [2:0] bus_bc;
  logic [63:0] bus_wdata, bus_rdata = RDAT;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  sbus_cmd_chan #(.TIMEOUT_CYC(TMO)) i_sbus_cmd_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_opc(bus_opc), .bus_sid(bus_sid),
    .bus_addr(bus_addr), .bus_bc(bus_bc), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_nack(bus_nack), .bus_rdata(bus_rdata));

  function automatic logic [31:0] mkc(input int op, input int sid, input int a, input int bc);
    return (32'(op) << 27) | (32'(sid) << 20) | (32'(a) << 4) | 32'(bc);
  endfunction

  typedef struct packed {
    logic [31:0] cmd;
    logic [1:0]  resp;   // 0 ack, 1 nack, 2 none expected
    logic [3:0]  st;
    logic [63:0] wb;
    logic [31:0] r0;
    logic [31:0] r1;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{mkc(14, 2, 16'h1234, 1), 2'd0, 4'h1, 64'h000000000000A1A0, 32'h0, 32'h0},
    '{mkc(15, 3, 16'h00FF, 2), 2'd0, 4'h1, 64'h0, 32'h00332211, 32'h0},
    '{mkc(1, 0, 16'hABCD, 7),  2'd0, 4'h1, 64'h0, 32'h44332211, 32'h88776655},
    '{mkc(0, 4, 16'h0010, 5),  2'd0, 4'h1, 64'h0000B5B4A3A2A1A0, 32'h44332211, 32'h88776655},
    '{mkc(13, 6, 16'h0200, 4), 2'd1, 4'h3, 64'h0, 32'h44332211, 32'h88776655},
    '{mkc(4, 5, 16'h0000, 6),  2'd0, 4'h1, 64'h0, 32'h44332211, 32'h88776655},
    '{mkc(8, 15, 16'hFFFF, 4), 2'd0, 4'h1, 64'h0, 32'h44332211, 32'h00000055},
    '{mkc(11, 1, 16'h0001, 0), 2'd2, 4'h3, 64'h0, 32'h44332211, 32'h00000055},
    '{mkc(20, 1, 16'h0001, 0), 2'd2, 4'h3, 64'h0, 32'h44332211, 32'h00000055},
    '{mkc(16, 7, 16'h0300, 3), 2'd0, 4'h1, 64'h00000000A3A2A1A0, 32'h44332211, 32'h00000055},
    '{mkc(2, 8, 16'h4400, 7),  2'd0, 4'h1, 64'hB7B6B5B4A3A2A1A0, 32'h44332211, 32'h00000055},
    '{mkc(9, 9, 16'h0055, 0),  2'd0, 4'h1, 64'h00000000000000A0, 32'h44332211, 32'h00000055}
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic respond(input logic nack);
    repeat (2) @(negedge clk);
    bus_ack = !nack; bus_nack = nack;
    @(negedge clk); bus_ack = 1'b0; bus_nack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 req", 64'(bus_req), 64'd0);
    reg_read(A_STAT, d); check("R1 status", 64'(d), 64'd0);
    reg_read(A_CFG, d);  check("R1 config", 64'(d), 64'h0000FFFF);
    reg_read(A_RD0, d);  check("R1 rdata0", 64'(d), 64'd0);
    reg_read(A_RD1, d);  check("R1 rdata1", 64'(d), 64'd0);
    reg_read(A_CMD, d);  check("R1 cmd", 64'(d), 64'd0);

    reg_write(A_WD0, WD0);
    reg_write(A_WD1, WD1);
    for (int k = 0; k < 12; k++) begin
      reg_write(A_CMD, VEC[k].cmd);
      if (VEC[k].resp != 2'd2) begin
        check("R2 req rise", 64'(bus_req), 64'd1);
        check("R2 opc", 64'(bus_opc), 64'(VEC[k].cmd[31:27]));
        check("R2 sid", 64'(bus_sid), 64'(VEC[k].cmd[23:20]));
        check("R2 addr", 64'(bus_addr), 64'(VEC[k].cmd[19:4]));
        if (VEC[k].cmd[31:27] >= 5'd3 && VEC[k].cmd[31:27] <= 5'd7)
          check("R12 bc forced zero", 64'(bus_bc), 64'd0);
        else
          check("R2 bc", 64'(bus_bc), 64'(VEC[k].cmd[2:0]));
        check("R3 wdata", bus_wdata, VEC[k].wb);
        respond(VEC[k].resp[0]);
        check("R5 req fall", 64'(bus_req), 64'd0);
      end else begin
        check("R8 no req", 64'(bus_req), 64'd0);
      end
      reg_read(A_STAT, d);
      check(VEC[k].resp == 2'd1 ? "R6 status" : (VEC[k].resp == 2'd2 ? "R8 status" : "R5 status"),
            64'(d), 64'(VEC[k].st));
      reg_read(A_RD0, d); check("R4 rdata0", 64'(d), 64'(VEC[k].r0));
      reg_read(A_RD1, d); check("R4 rdata1", 64'(d), 64'(VEC[k].r1));
    end

    // R7 denied target
    reg_write(A_CFG, 32'h0000FFFB);
    reg_write(A_CMD, mkc(15, 2, 16'h0100, 0));
    check("R7 no req", 64'(bus_req), 64'd0);
    reg_read(A_STAT, d); check("R7 status", 64'(d), 64'h5);
    reg_write(A_CFG, 32'h0000FFFF);

    // R10 command while busy; R3 snapshot
    reg_write(A_CMD, mkc(14, 1, 16'h0042, 0));
    check("R3 wdata start", bus_wdata, 64'hA0);
    reg_write(A_WD0, 32'h11111111);
    reg_write(A_CMD, mkc(14, 1, 16'h0077, 3));
    check("R10 addr kept", 64'(bus_addr), 64'h42);
    check("R3 wdata snapshot", bus_wdata, 64'hA0);
    reg_read(A_STAT, d); check("R10 status busy", 64'(d), 64'h9);
    reg_read(A_CMD, d);  check("R10 cmd kept", 64'(d), 64'(mkc(14, 1, 16'h0042, 0)));
    respond(1'b0);
    reg_read(A_STAT, d); check("R10 status after ack", 64'(d), 64'h9);

    // R11 new command clears status
    reg_write(A_CMD, mkc(15, 1, 16'h0010, 0));
    reg_read(A_STAT, d); check("R11 status cleared", 64'(d), 64'h0);
    check("R11 req", 64'(bus_req), 64'd1);
    respond(1'b0);
    reg_read(A_STAT, d); check("R11 status done", 64'(d), 64'h1);

    // R10 command write in the same cycle as the acknowledge
    bus_rdata = 64'h00000000000000EE;
    reg_write(A_CMD, mkc(15, 1, 16'h0020, 0));
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = A_CMD; reg_wdata = mkc(15, 1, 16'h0030, 0); bus_ack = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; bus_ack = 1'b0;
    check("R10 collide req", 64'(bus_req), 64'd0);
    reg_read(A_STAT, d); check("R10 collide status", 64'(d), 64'h9);
    reg_read(A_RD0, d);  check("R4 collide rdata", 64'(d), 64'hEE);
    @(negedge clk);
    check("R10 collide not started", 64'(bus_req), 64'd0);
    check("R10 collide addr", 64'(bus_addr), 64'h20);
    bus_rdata = RDAT;

    // R9 timeout
    reg_write(A_CMD, mkc(14, 0, 16'h0005, 0));
    repeat (TMO - 1) @(negedge clk);
    check("R9 req before limit", 64'(bus_req), 64'd1);
    @(negedge clk);
    check("R9 req dropped", 64'(bus_req), 64'd0);
    reg_read(A_STAT, d); check("R9 status", 64'(d), 64'h9);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule